// File: doc/BRIEF.md
# Region Jump-and-Link with Mode Exchange

This block decodes and carries out a jump-and-link that stays inside an aligned address region and flips the processor's instruction-set mode bit. The jump has one branch delay slot. On the accepted jump the block issues a write to the link register. The link value is the address two instructions past the jump, and bit 0 of that value carries the mode that was in force when the jump was decoded. The block then holds the target and the inverted mode. When the next instruction (the delay slot) is accepted, it releases them as one redirect.

The target is not an offset added to the PC. Its upper bits come from the delay-slot address and the rest is the 26-bit index field shifted left by two. A jump in the last word of a 256 MB region therefore lands in the following region. The jump only exists when at least one compressed instruction set is present; otherwise it raises a reserved-instruction exception and has no other effect. A control-transfer instruction in the delay slot is flagged for diagnosis, and the first jump's redirect goes ahead unchanged.

All outputs are registered and change one clock after the accepting edge. Stalled cycles (`instr_valid` low) leave the sequencer untouched.

Top module: `region_jump_unit`

## Requirements
- R1: An instruction is the mode-exchanging jump only when bits 31:26 equal 6'b011101. Any other accepted word outside a delay slot leaves `link_we`, `exc_ri`, `pending` and `redirect_valid` at 0.
- R2: One clock after a jump is accepted with at least one of `cx_present` set, `link_we` is 1 for one cycle, `link_idx` is 31, and `link_data` equals `pc + 8` with bit 0 replaced by `isa_mode`.
- R3: Bits 27:0 of the redirect target are `instr[25:0]` followed by two zero bits, so the target is always word aligned.
- R4: Bits 31:28 of the target come from `pc + 4`. For a jump at the last word of a region, including 32'hFFFFFFFC, these bits belong to the next region (with wrap-around).
- R5: `pending` is 1 from the clock after the jump until the delay slot is accepted. One clock after the delay slot is accepted, `redirect_valid` pulses for one cycle together with `redirect_target` and `redirect_mode`, and `redirect_mode` equals the inverse of the mode sampled at the jump.
- R6: Cycles with `instr_valid` low do not use up the delay slot. `pending` holds and `redirect_valid` stays 0.
- R7: If both `cx_present` bits are 0, an accepted jump makes `exc_ri` pulse one clock later. `link_we` stays 0, `pending` stays 0, and no redirect follows.
- R8: A delay-slot word is a control transfer when bits 31:26 lie in 1..7, equal 6'b011101, or equal 0 with bits 5:0 equal to 6'b001000 or 6'b001001. Such a word makes `ds_cti` pulse together with the redirect. The redirect still carries the first jump's target and mode, and the word causes no link write and no new pending jump.
- R9: While `rst` is high and on the clock after it, all pulse outputs and `pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction accepted this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of `instr` |
| isa_mode | input | 1 | Current instruction-set mode |
| cx_present | input | 2 | Presence flags of the two compressed instruction sets |
| link_we | output | 1 | Link register write strobe |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Link value |
| pending | output | 1 | Jump waiting for its delay slot |
| redirect_valid | output | 1 | Redirect strobe after the delay slot |
| redirect_target | output | 32 | Redirect address |
| redirect_mode | output | 1 | Mode to use from the redirect on |
| exc_ri | output | 1 | Reserved-instruction exception strobe |
| ds_cti | output | 1 | Control transfer seen in the delay slot |

## Verification
The bench sweeps all presence-flag combinations and both modes over a set of PCs that includes region-final words and the top of the address space. A design that took the upper target bits from the jump's own PC would land in the wrong region there. A design that let a stall count as the delay slot would redirect one instruction early. A design that decoded a jump in the delay slot would write the link register twice or replace the first target. A design that skipped the presence check would redirect where it should trap.

// File: rtl/rju_pkg.sv
package rju_pkg;
  localparam logic [5:0] OP_XJAL   = 6'b011101;
  localparam logic [5:0] OP_SPEC   = 6'b000000;
  localparam logic [5:0] FN_JR     = 6'b001000;
  localparam logic [5:0] FN_JALR   = 6'b001001;
  localparam logic [5:0] OP_CT_LO  = 6'd1;
  localparam logic [5:0] OP_CT_HI  = 6'd7;

  function automatic logic is_ctl(input logic [5:0] op, input logic [5:0] fn);
    return ((op >= OP_CT_LO) && (op <= OP_CT_HI)) || (op == OP_XJAL) ||
           ((op == OP_SPEC) && ((fn == FN_JR) || (fn == FN_JALR)));
  endfunction
endpackage

// File: rtl/rju_decode.sv
module rju_decode #(
  parameter int NCX = 2
) (
  input  logic [5:0]     op,
  input  logic [5:0]     fn,
  input  logic [NCX-1:0] cx_present,
  output logic           hit,
  output logic           ctl,
  output logic           unsupported
);
  import rju_pkg::*;

  always_comb begin
    hit         = (op == OP_XJAL);
    ctl         = is_ctl(op, fn);
    unsupported = ~(|cx_present);
  end
endmodule

// File: rtl/rju_target.sv
module rju_target #(
  parameter int XLEN        = 32,
  parameter int REGION_BITS = 28
) (
  input  logic [XLEN-1:0]          pc,
  input  logic [REGION_BITS-3:0]   idx,
  input  logic                     mode,
  output logic [XLEN-1:0]          target,
  output logic [XLEN-1:0]          link
);
  localparam int STEP = 4;
  logic [XLEN-1:0] ds_pc;
  logic [XLEN-1:0] ret_pc;

  always_comb begin
    ds_pc  = pc + XLEN'(STEP);
    ret_pc = pc + XLEN'(2 * STEP);
    target = {ds_pc[XLEN-1:REGION_BITS], idx, 2'b00};
    link   = {ret_pc[XLEN-1:1], mode};
  end
endmodule

// File: rtl/rju_seq.sv
module rju_seq #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            hit,
  input  logic            ctl,
  input  logic            unsupported,
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] link,
  input  logic            mode,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            pend_q,
  output logic            redir_v,
  output logic [XLEN-1:0] redir_tgt,
  output logic            redir_mode,
  output logic            exc_ri,
  output logic            ds_cti
);
  logic [XLEN-1:0] tgt_q;
  logic            mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_we    <= 1'b0;
      link_data  <= '0;
      pend_q     <= 1'b0;
      redir_v    <= 1'b0;
      redir_tgt  <= '0;
      redir_mode <= 1'b0;
      exc_ri     <= 1'b0;
      ds_cti     <= 1'b0;
      tgt_q      <= '0;
      mode_q     <= 1'b0;
    end else begin
      link_we <= 1'b0;
      redir_v <= 1'b0;
      exc_ri  <= 1'b0;
      ds_cti  <= 1'b0;
      if (valid) begin
        if (pend_q) begin
          pend_q     <= 1'b0;
          redir_v    <= 1'b1;
          redir_tgt  <= tgt_q;
          redir_mode <= mode_q;
          ds_cti     <= ctl;
        end else if (hit) begin
          if (unsupported) begin
            exc_ri <= 1'b1;
            tgt_q  <= '0;
            mode_q <= 1'b0;
          end else begin
            link_we   <= 1'b1;
            link_data <= link;
            pend_q    <= 1'b1;
            tgt_q     <= target;
            mode_q    <= ~mode;
          end
        end
      end
    end
  end

  // R5
  redir_after_pend_chk: assert property (@(posedge clk) disable iff (rst)
    redir_v |-> $past(pend_q));
  // R6
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(pend_q) && !redir_v));
  // R7
  exc_no_link_chk: assert property (@(posedge clk) disable iff (rst)
    exc_ri |-> (!link_we && !pend_q));
  // R2
  link_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> pend_q);
  // R8
  cti_with_redir_chk: assert property (@(posedge clk) disable iff (rst)
    ds_cti |-> (redir_v && !link_we));
  // R3
  redir_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    redir_v |-> (redir_tgt[1:0] == 2'b00));
endmodule

// File: rtl/region_jump_unit.sv
module region_jump_unit #(
  parameter int XLEN        = 32,
  parameter int REGION_BITS = 28,
  parameter int NCX         = 2,
  parameter int RIDX_W      = 5,
  parameter int LINK_REG    = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   pc,
  input  logic              isa_mode,
  input  logic [NCX-1:0]    cx_present,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_data,
  output logic              pending,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_target,
  output logic              redirect_mode,
  output logic              exc_ri,
  output logic              ds_cti
);
  localparam int IDX_W = REGION_BITS - 2;

  logic            hit, ctl, unsupported;
  logic [XLEN-1:0] target, link;

  rju_decode #(.NCX(NCX)) u_dec (
    .op          (instr[31:26]),
    .fn          (instr[5:0]),
    .cx_present  (cx_present),
    .hit         (hit),
    .ctl         (ctl),
    .unsupported (unsupported)
  );

  rju_target #(.XLEN(XLEN), .REGION_BITS(REGION_BITS)) u_tgt (
    .pc     (pc),
    .idx    (instr[IDX_W-1:0]),
    .mode   (isa_mode),
    .target (target),
    .link   (link)
  );

  rju_seq #(.XLEN(XLEN)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .valid       (instr_valid),
    .hit         (hit),
    .ctl         (ctl),
    .unsupported (unsupported),
    .target      (target),
    .link        (link),
    .mode        (isa_mode),
    .link_we     (link_we),
    .link_data   (link_data),
    .pend_q      (pending),
    .redir_v     (redirect_valid),
    .redir_tgt   (redirect_target),
    .redir_mode  (redirect_mode),
    .exc_ri      (exc_ri),
    .ds_cti      (ds_cti)
  );

  assign link_idx = RIDX_W'(LINK_REG);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!link_we && !pending && !redirect_valid && !exc_ri && !ds_cti));
  // R1
  nonjump_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !pending && !hit) |=> (!link_we && !exc_ri && !pending));
endmodule

// File: tb/region_jump_unit_tb.sv
module region_jump_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        isa_mode = 1'b0;
  logic [1:0]  cx_present = 2'b00;
  logic        link_we, pending, redirect_valid, redirect_mode, exc_ri, ds_cti;
  logic [4:0]  link_idx;
  logic [31:0] link_data, redirect_target;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  region_jump_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .pc(pc),
    .isa_mode(isa_mode), .cx_present(cx_present), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data), .pending(pending),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .redirect_mode(redirect_mode), .exc_ri(exc_ri), .ds_cti(ds_cti)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one word at a negedge, return at the following negedge with valid low
  task automatic issue(input logic [31:0] w, input logic [31:0] p);
    instr_valid = 1'b1; instr = w; pc = p;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pcs [6];
    pcs[0] = 32'h0000_0000; pcs[1] = 32'h0FFF_FFFC; pcs[2] = 32'h1234_5678;
    pcs[3] = 32'hEFFF_FFF8; pcs[4] = 32'hFFFF_FFFC; pcs[5] = 32'h7FFF_FFFC;
    repeat (3) @(negedge clk);
    // R9
    chk(!link_we && !pending && !redirect_valid && !exc_ri && !ds_cti, "R9 reset", {27'd0, link_we, pending, redirect_valid, exc_ri, ds_cti}, 0);
    rst = 1'b0;
    idle();
    chk(!pending && !redirect_valid, "R9 after reset", {30'd0, pending, redirect_valid}, 0);

    // R1: non-jump words
    for (int k = 0; k < 64; k++) begin
      if (6'(k) == 6'b011101) continue;
      cx_present = 2'b11;
      issue({6'(k), 26'h155_5555}, 32'h100 + 32'(k * 4));
      chk(!link_we && !exc_ri && !pending && !redirect_valid, "R1 non-jump quiet",
          {28'd0, link_we, exc_ri, pending, redirect_valid}, 0);
    end

    for (int f = 0; f < 4; f++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 6; k++) begin
          logic [25:0] idx;
          logic [31:0] p, exp_link, exp_tgt, ds_pc;
          idx = 26'((k + 1 + f * 7 + m * 3) * 32'h0135_79BD);
          p = pcs[k];
          ds_pc = p + 32'd4;
          exp_link = {(p + 32'd8) & 32'hFFFF_FFFE} | 32'(m);
          exp_tgt = {ds_pc[31:28], idx, 2'b00};
          cx_present = 2'(f);
          isa_mode = m[0];
          issue({6'b011101, idx}, p);
          if (f == 0) begin
            // R7
            chk(exc_ri && !link_we && !pending, "R7 exception no effect",
                {29'd0, exc_ri, link_we, pending}, 32'h4);
            issue(32'h0, ds_pc);
            chk(!redirect_valid && !exc_ri, "R7 no redirect", {30'd0, redirect_valid, exc_ri}, 0);
          end else begin
            // R2
            chk(link_we && link_idx == 5'd31, "R2 link write", {26'd0, link_we, link_idx}, 32'h3F);
            chk(link_data == exp_link, "R2 link data", link_data, exp_link);
            chk(pending && !exc_ri && !redirect_valid, "R5 pending after jump",
                {29'd0, pending, exc_ri, redirect_valid}, 32'h4);
            // R6: stall cycles
            for (int s = 0; s < (k % 3); s++) begin
              idle();
              chk(pending && !redirect_valid && !link_we, "R6 stall holds",
                  {29'd0, pending, redirect_valid, link_we}, 32'h4);
            end
            if (k == 2 && m == 1) begin
              // R8: control transfer in delay slot
              issue({6'b011101, ~idx}, ds_pc);
              chk(ds_cti && redirect_valid && !link_we, "R8 cti flag",
                  {29'd0, ds_cti, redirect_valid, link_we}, 32'h6);
              chk(redirect_target == exp_tgt, "R8 first target kept", redirect_target, exp_tgt);
              idle();
              chk(!pending && !link_we && !redirect_valid, "R8 no second jump",
                  {29'd0, pending, link_we, redirect_valid}, 0);
            end else begin
              issue(32'h0000_0020, ds_pc);
              chk(redirect_valid && !pending && !ds_cti, "R5 redirect pulse",
                  {29'd0, redirect_valid, pending, ds_cti}, 32'h4);
              // R3 R4
              chk(redirect_target == exp_tgt, "R3 R4 target", redirect_target, exp_tgt);
              chk(redirect_mode == ~m[0], "R5 mode toggled", {31'd0, redirect_mode}, {31'd0, ~m[0]});
              idle();
              chk(!redirect_valid, "R5 single pulse", {31'd0, redirect_valid}, 0);
            end
          end
        end
      end
    end

    // R4 explicit boundary: last word of region 0 goes to region 1
    cx_present = 2'b01; isa_mode = 1'b0;
    issue({6'b011101, 26'h0000010}, 32'h0FFF_FFFC);
    issue(32'h0, 32'h1000_0000);
    chk(redirect_target == 32'h1000_0040, "R4 region boundary", redirect_target, 32'h1000_0040);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule